// File: doc/BRIEF.md
# Waveform Digitizer Acquisition Controller

This block sequences sample capture for a multi-channel waveform digitizer. It takes start and stop requests from a one-cycle register command or from two groups of external pulse lines (a front-panel pair and a backplane pair), each group enabled on its own. For every accepted capture it drives a write strobe, a bank select and a sample address toward an event memory holding two banks. Every clock cycle is one sample tick. The ADC front end, the memory array and the readout path are not part of this block.

A capture is accepted only while at least one bank is armed. Optional tick delays can push the first sample later and the last sample further out. A gate mode takes the capture window from the width of the external start level. The event length is chosen from eight sizes. The address either rolls over at the end of the event or stops the capture there. When a capture finishes, both banks are disarmed, a sticky done flag is set, an event counter advances and its new value is stored against the bank that was written. An optional one-cycle trigger pulse marks the stop.

Top module: `wfd_acq_ctrl`

## Requirements
- R1: With the start delay off, or programmed as 0, the first write happens in the cycle right after the edge that samples `cmd_start`. With the delay on and set to D > 0, the first write comes D cycles later than that.
- R2: Outside gate mode, a stop with the stop delay off ends the capture at the edge that samples it, so no write follows that edge. With the stop delay on and set to D > 0, exactly D further writes follow.
- R3: In gate mode, the number of writes equals the number of cycles the enabled external start level is high. `cmd_start`, `cmd_stop`, the stop lines and both delays have no effect.
- R4: With `wrap_en` = 1, the address after the last address of the event is 0 and capture continues. Addresses otherwise step by one from 0 on each write.
- R5: With `wrap_en` = 0, the capture ends after the write to the last address of the event, even without a stop.
- R6: `size_sel` codes 0 to 7 give event lengths of 128, 256, 512, 1024, 2048, 4096, 16384 and 131072 samples. The last address is the length minus 1.
- R7: A start is ignored while no bank is armed. The capture writes into the armed bank, and bank 0 wins when both are armed (`mem_bank` 0 = bank 0). Bit i of `arm_req` / `disarm_req` / `armed` refers to bank i.
- R8: When a capture ends, `armed` reads 00 and `done` reads 1. `done` returns to 0 after any `arm_req` bit is pulsed. An end of capture takes priority over a same-cycle arm.
- R9: With `trig_on_stop` = 1, `trig_out` is high for exactly one cycle: the first cycle after the final write. With it at 0, `trig_out` stays low.
- R10: A shared event count starts at 0 and goes up by one per completed capture. The new value is copied into `evt_num0` or `evt_num1` for the bank just written.
- R11: External lines pass through two flip-flops and are edge detected, so one pulse acts once however long it is held. A line group whose enable is low has no effect.
- R12: `busy` is high from the accepted start until the final write, and low out of reset, along with `done`, `armed`, `mem_we`, `trig_out` and both event numbers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle register start command |
| cmd_stop | input | 1 | One-cycle register stop command |
| fp_start | input | 1 | Front-panel start line (asynchronous) |
| fp_stop | input | 1 | Front-panel stop line (asynchronous) |
| bp_start | input | 1 | Backplane start line (asynchronous) |
| bp_stop | input | 1 | Backplane stop line (asynchronous) |
| fp_en | input | 1 | Enables the front-panel pair |
| bp_en | input | 1 | Enables the backplane pair |
| gate_mode | input | 1 | Window follows the external start level |
| start_dly_en | input | 1 | Start delay enable |
| start_dly | input | DLY_W | Start delay in ticks |
| stop_dly_en | input | 1 | Stop delay enable |
| stop_dly | input | DLY_W | Stop delay in ticks |
| size_sel | input | 3 | Event length code |
| wrap_en | input | 1 | Address rollover instead of halt |
| trig_on_stop | input | 1 | Enables the stop trigger pulse |
| arm_req | input | 2 | Per-bank arm pulse |
| disarm_req | input | 2 | Per-bank disarm pulse |
| mem_we | output | 1 | Sample write strobe |
| mem_bank | output | 1 | Bank being written |
| mem_addr | output | 17 | Sample address within the event |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Sticky capture-finished flag |
| armed | output | 2 | Per-bank armed state |
| trig_out | output | 1 | One-cycle stop trigger |
| evt_num0 | output | EVT_W | Latest event number stored for bank 0 |
| evt_num1 | output | EVT_W | Latest event number stored for bank 1 |

## Verification
The embedded properties assume that the event length, wrap, delay and mode settings stay fixed while `busy` is high. If `size_sel` changed mid-capture, the address could already sit past the new last address. The bench therefore changes configuration only while the block is idle. It holds every external line for at least two cycles, so the synchronizer catches each level, and it pulses register commands for one cycle only.

// File: rtl/wfd_acq_pkg.sv
package wfd_acq_pkg;

  localparam int unsigned ADDR_W = 17;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_RUN  = 2'd2,
    ST_POST = 2'd3
  } acq_state_e;

  // Last valid address of an event for a given length code.
  function automatic logic [ADDR_W-1:0] size_last(input logic [2:0] sel);
    int unsigned sh;
    logic [63:0] span;
    case (sel)
      3'd0:    sh = 7;
      3'd1:    sh = 8;
      3'd2:    sh = 9;
      3'd3:    sh = 10;
      3'd4:    sh = 11;
      3'd5:    sh = 12;
      3'd6:    sh = 14;
      default: sh = 17;
    endcase
    span = (64'd1 << sh) - 64'd1;
    return span[ADDR_W-1:0];
  endfunction

endpackage

// File: rtl/wfd_ext_edge.sv
module wfd_ext_edge #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned N_SRC       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  input  logic [N_SRC-1:0] src_en,
  output logic             lvl,
  output logic             rise
);

  logic [N_SRC-1:0] src_sync;
  logic             lvl_q;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], src_in[g]};
      end
      assign src_sync[g] = chain_q[SYNC_STAGES-1];
    end
  endgenerate

  assign lvl  = |(src_sync & src_en);
  assign rise = lvl & ~lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  // R11: one held pulse yields one event
  p_single_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/wfd_addr_gen.sv
module wfd_addr_gen
  import wfd_acq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [2:0]        size_sel,
  output logic [ADDR_W-1:0] addr,
  output logic              at_end
);

  logic [ADDR_W-1:0] addr_q, addr_d, last_a;

  assign last_a = size_last(size_sel);
  assign at_end = (addr_q == last_a);
  assign addr   = addr_q;

  always_comb begin
    addr_d = addr_q;
    if (clr)      addr_d = '0;
    else if (adv) addr_d = at_end ? '0 : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          addr_q <= '0;
    else if (clr || adv) addr_q <= addr_d;
  end

  // R6: a write never targets an address beyond the selected event length
  p_addr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (addr_q <= last_a));

endmodule

// File: rtl/wfd_bank_ctrl.sv
module wfd_bank_ctrl #(
  parameter int unsigned N_BANK = 2,
  parameter int unsigned EVT_W  = 16,
  localparam int unsigned BW    = (N_BANK > 1) ? $clog2(N_BANK) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_BANK-1:0]             arm_req,
  input  logic [N_BANK-1:0]             disarm_req,
  input  logic                          cap_end,
  input  logic [BW-1:0]                 cap_bank,
  output logic [N_BANK-1:0]             armed,
  output logic                          any_armed,
  output logic [BW-1:0]                 sel_bank,
  output logic                          done,
  output logic [N_BANK-1:0][EVT_W-1:0]  evt_num
);

  logic [N_BANK-1:0]            armed_q, armed_d;
  logic                         done_q, done_d;
  logic [EVT_W-1:0]             evt_cnt_q, evt_cnt_d;
  logic [N_BANK-1:0][EVT_W-1:0] evt_num_q, evt_num_d;

  assign armed     = armed_q;
  assign any_armed = |armed_q;
  assign done      = done_q;
  assign evt_num   = evt_num_q;

  // Lowest armed bank index wins
  always_comb begin
    sel_bank = '0;
    for (int i = N_BANK - 1; i >= 0; i--) begin
      if (armed_q[i]) sel_bank = BW'(i);
    end
  end

  always_comb begin
    for (int i = 0; i < N_BANK; i++) begin
      if (cap_end)            armed_d[i] = 1'b0;
      else if (disarm_req[i]) armed_d[i] = 1'b0;
      else if (arm_req[i])    armed_d[i] = 1'b1;
      else                    armed_d[i] = armed_q[i];
    end
    if (cap_end)       done_d = 1'b1;
    else if (|arm_req) done_d = 1'b0;
    else               done_d = done_q;
    evt_cnt_d = evt_cnt_q;
    evt_num_d = evt_num_q;
    if (cap_end) begin
      evt_cnt_d           = evt_cnt_q + 1'b1;
      evt_num_d[cap_bank] = evt_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= '0;
      done_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_cnt_q <= '0;
      evt_num_q <= '0;
    end else if (cap_end) begin
      evt_cnt_q <= evt_cnt_d;
      evt_num_q <= evt_num_d;
    end
  end

endmodule

// File: rtl/wfd_acq_ctrl.sv
module wfd_acq_ctrl
  import wfd_acq_pkg::*;
#(
  parameter int unsigned DLY_W       = 8,
  parameter int unsigned EVT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              fp_start,
  input  logic              fp_stop,
  input  logic              bp_start,
  input  logic              bp_stop,
  input  logic              fp_en,
  input  logic              bp_en,
  input  logic              gate_mode,
  input  logic              start_dly_en,
  input  logic [DLY_W-1:0]  start_dly,
  input  logic              stop_dly_en,
  input  logic [DLY_W-1:0]  stop_dly,
  input  logic [2:0]        size_sel,
  input  logic              wrap_en,
  input  logic              trig_on_stop,
  input  logic [1:0]        arm_req,
  input  logic [1:0]        disarm_req,
  output logic              mem_we,
  output logic              mem_bank,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              busy,
  output logic              done,
  output logic [1:0]        armed,
  output logic              trig_out,
  output logic [EVT_W-1:0]  evt_num0,
  output logic [EVT_W-1:0]  evt_num1
);

  localparam int unsigned N_BANK = 2;
  localparam int unsigned N_SRC  = 2;

  acq_state_e        state_q, state_d;
  logic [DLY_W-1:0]  cnt_q, cnt_d;
  logic              bank_q, bank_d;
  logic              trig_q;

  logic              st_lvl, st_rise, sp_rise;
  logic              unused_sp_lvl;
  logic              at_end, any_armed, sel_bank;
  logic              start_ok, cap_end, writing;
  logic              start_evt, stop_evt, gate_closed, buf_full;
  logic [N_BANK-1:0][EVT_W-1:0] evt_num_w;

  wfd_ext_edge #(.SYNC_STAGES(SYNC_STAGES), .N_SRC(N_SRC)) u_start_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_in ({bp_start, fp_start}),
    .src_en ({bp_en, fp_en}),
    .lvl    (st_lvl),
    .rise   (st_rise)
  );

  wfd_ext_edge #(.SYNC_STAGES(SYNC_STAGES), .N_SRC(N_SRC)) u_stop_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_in ({bp_stop, fp_stop}),
    .src_en ({bp_en, fp_en}),
    .lvl    (unused_sp_lvl),
    .rise   (sp_rise)
  );

  wfd_addr_gen u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_ok),
    .adv      (writing),
    .size_sel (size_sel),
    .addr     (mem_addr),
    .at_end   (at_end)
  );

  wfd_bank_ctrl #(.N_BANK(N_BANK), .EVT_W(EVT_W)) u_banks (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_req    (arm_req),
    .disarm_req (disarm_req),
    .cap_end    (cap_end),
    .cap_bank   (bank_q),
    .armed      (armed),
    .any_armed  (any_armed),
    .sel_bank   (sel_bank),
    .done       (done),
    .evt_num    (evt_num_w)
  );

  assign evt_num0    = evt_num_w[0];
  assign evt_num1    = evt_num_w[1];
  assign writing     = (state_q == ST_RUN) || (state_q == ST_POST);
  assign mem_we      = writing;
  assign mem_bank    = bank_q;
  assign busy        = (state_q != ST_IDLE);
  assign trig_out    = trig_q;

  assign start_evt   = gate_mode ? st_rise : (cmd_start | st_rise);
  assign stop_evt    = !gate_mode && (cmd_stop | sp_rise);
  assign gate_closed = gate_mode && !st_lvl;
  assign buf_full    = at_end && !wrap_en;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    bank_d   = bank_q;
    start_ok = 1'b0;
    cap_end  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_evt && any_armed) begin
          start_ok = 1'b1;
          bank_d   = sel_bank;
          if (!gate_mode && start_dly_en && (start_dly != '0)) begin
            state_d = ST_PRE;
            cnt_d   = start_dly;
          end else begin
            state_d = ST_RUN;
          end
        end
      end
      ST_PRE: begin
        if (cnt_q <= DLY_W'(1)) state_d = ST_RUN;
        else                    cnt_d   = cnt_q - 1'b1;
      end
      ST_RUN: begin
        if (buf_full || gate_closed) begin
          cap_end = 1'b1;
        end else if (stop_evt) begin
          if (stop_dly_en && (stop_dly != '0)) begin
            state_d = ST_POST;
            cnt_d   = stop_dly;
          end else begin
            cap_end = 1'b1;
          end
        end
      end
      ST_POST: begin
        if (buf_full || (cnt_q <= DLY_W'(1))) cap_end = 1'b1;
        else                                  cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (cap_end) state_d = ST_IDLE;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bank_q  <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      trig_q  <= cap_end & trig_on_stop;
      if (state_d == ST_PRE || state_d == ST_POST) cnt_q <= cnt_d;
      if (start_ok) bank_q <= bank_d;
    end
  end

  // R7: a capture only begins while some bank was armed
  p_start_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(armed) != 2'b00));

  // R8: end of capture leaves no bank armed and raises done
  p_end_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (armed == 2'b00 && done));

  // R9: the stop trigger lasts a single cycle
  p_trig_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out);

  // R9: the stop trigger follows the final write
  p_trig_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> (!busy && $past(busy)));

  // R12: no write strobe once busy has dropped
  p_we_in_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);

endmodule

// File: tb/wfd_acq_ctrl_tb.sv
module wfd_acq_ctrl_tb;
  import wfd_acq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DLY_W = 8;
  localparam int EVT_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_start, cmd_stop, fp_start, fp_stop, bp_start, bp_stop;
  logic fp_en, bp_en, gate_mode, start_dly_en, stop_dly_en, wrap_en, trig_on_stop;
  logic [DLY_W-1:0] start_dly, stop_dly;
  logic [2:0] size_sel;
  logic [1:0] arm_req, disarm_req;
  logic mem_we, mem_bank, busy, done, trig_out;
  logic [ADDR_W-1:0] mem_addr;
  logic [1:0] armed;
  logic [EVT_W-1:0] evt_num0, evt_num1;

  always #(CLK_PERIOD/2) clk = ~clk;

  wfd_acq_ctrl #(.DLY_W(DLY_W), .EVT_W(EVT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .fp_start(fp_start), .fp_stop(fp_stop), .bp_start(bp_start), .bp_stop(bp_stop),
    .fp_en(fp_en), .bp_en(bp_en), .gate_mode(gate_mode),
    .start_dly_en(start_dly_en), .start_dly(start_dly),
    .stop_dly_en(stop_dly_en), .stop_dly(stop_dly),
    .size_sel(size_sel), .wrap_en(wrap_en), .trig_on_stop(trig_on_stop),
    .arm_req(arm_req), .disarm_req(disarm_req),
    .mem_we(mem_we), .mem_bank(mem_bank), .mem_addr(mem_addr),
    .busy(busy), .done(done), .armed(armed), .trig_out(trig_out),
    .evt_num0(evt_num0), .evt_num1(evt_num1)
  );

  int n_chk = 0;
  int n_bad = 0;
  int trig_cnt = 0;
  logic [ADDR_W:0] exp_q[$];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: every write is compared with the next expected item
  always @(negedge clk) begin
    if (rst_n) begin
      if (trig_out) trig_cnt++;
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          n_chk++;
          n_bad++;
          $display("FAIL R7 unexpected write: actual bank=%0d addr=%0d expected=none",
                   mem_bank, mem_addr);
        end else begin
          logic [ADDR_W:0] item;
          item = exp_q.pop_front();
          chk("R4", "write {bank,addr}", longint'({mem_bank, mem_addr}), longint'(item));
        end
      end
    end
  end

  // Driver side: expected writes for one capture
  task automatic push_run(input bit bank, input int n, input int len);
    for (int i = 0; i < n; i++) exp_q.push_back({bank, ADDR_W'(i % len)});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic arm(input logic [1:0] m);
    @(posedge clk); #1 arm_req = m;
    @(posedge clk); #1 arm_req = 2'b00;
    @(negedge clk);
    chk("R8", "armed after arm", armed, m);
    chk("R8", "done cleared by arm", done, 0);
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 cmd_start = 1'b1;
    @(posedge clk); #1 cmd_start = 1'b0;
  endtask

  task automatic stop_after(input int w);
    repeat (w - 1) @(posedge clk);
    #1 cmd_stop = 1'b1;
    @(posedge clk); #1 cmd_stop = 1'b0;
  endtask

  task automatic flushed(input string req);
    chk(req, "pending expected writes", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int k;
    int trig_base;
    rst_n = 1'b0;
    {cmd_start, cmd_stop, fp_start, fp_stop, bp_start, bp_stop} = '0;
    {fp_en, bp_en, gate_mode, start_dly_en, stop_dly_en, wrap_en, trig_on_stop} = '0;
    start_dly = '0; stop_dly = '0; size_sel = 3'd0;
    arm_req = 2'b00; disarm_req = 2'b00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    chk("R12", "busy at reset", busy, 0);
    chk("R12", "done at reset", done, 0);
    chk("R12", "armed at reset", armed, 0);
    chk("R12", "mem_we at reset", mem_we, 0);
    chk("R12", "evt_num0 at reset", evt_num0, 0);

    // R7: start without any armed bank is ignored
    pulse_start();
    repeat (5) @(negedge clk);
    chk("R7", "busy after unarmed start", busy, 0);

    // R1/R5/R9/R10: 128-sample event, no delay, halt at end, trigger on
    trig_on_stop = 1'b1;
    arm(2'b01);
    push_run(1'b0, 128, 128);
    pulse_start();
    @(negedge clk);
    chk("R1", "write right after start", mem_we, 1);
    chk("R12", "busy during capture", busy, 1);
    wait_idle();
    flushed("R5");
    chk("R8", "done after end", done, 1);
    chk("R8", "armed after end", armed, 0);
    chk("R9", "trigger pulses", trig_cnt, 1);
    chk("R10", "evt_num0", evt_num0, 1);

    // R1: start delay of 7 into bank 1, trigger off
    trig_on_stop = 1'b0;
    trig_base = trig_cnt;
    start_dly_en = 1'b1; start_dly = 8'd7;
    arm(2'b10);
    push_run(1'b1, 128, 128);
    pulse_start();
    @(negedge clk);
    k = 0;
    while (!mem_we && k < 50) begin k++; @(negedge clk); end
    chk("R1", "start delay cycles", k, 7);
    wait_idle();
    flushed("R1");
    chk("R10", "evt_num1", evt_num1, 2);
    chk("R9", "no trigger when disabled", trig_cnt, trig_base);
    start_dly_en = 1'b0;

    // R2/R4/R7: both banks armed, wrap on, stop at 200 plus stop delay 5
    wrap_en = 1'b1; stop_dly_en = 1'b1; stop_dly = 8'd5;
    arm(2'b11);
    push_run(1'b0, 205, 128);
    pulse_start();
    stop_after(200);
    wait_idle();
    flushed("R2");
    chk("R10", "evt_num0 after wrap run", evt_num0, 3);
    chk("R8", "both banks disarmed", armed, 0);

    // R2: stop without delay, 512 length, no wrap
    wrap_en = 1'b0; stop_dly_en = 1'b0; size_sel = 3'd2;
    arm(2'b01);
    push_run(1'b0, 300, 512);
    pulse_start();
    stop_after(300);
    wait_idle();
    flushed("R2");

    // R6/R5: 1024 length in bank 1 runs to the end by itself
    size_sel = 3'd3;
    arm(2'b10);
    push_run(1'b1, 1024, 1024);
    pulse_start();
    wait_idle();
    flushed("R6");
    chk("R10", "evt_num1 after full event", evt_num1, 5);

    // R3: gate mode, 40-cycle gate, stops and delays ignored
    size_sel = 3'd0; gate_mode = 1'b1; fp_en = 1'b1;
    start_dly_en = 1'b1; stop_dly_en = 1'b1;
    arm(2'b01);
    push_run(1'b0, 40, 128);
    @(posedge clk); #1 fp_start = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (i == 10) cmd_stop = 1'b1;
      if (i == 11) cmd_stop = 1'b0;
      if (i == 15) fp_stop = 1'b1;
      if (i == 18) fp_stop = 1'b0;
    end
    fp_start = 1'b0;
    wait_idle();
    flushed("R3");
    chk("R10", "evt_num0 after gate", evt_num0, 6);
    gate_mode = 1'b0; fp_en = 1'b0; start_dly_en = 1'b0; stop_dly_en = 1'b0;

    // R11: disabled backplane lines are ignored
    arm(2'b01);
    @(posedge clk); #1 bp_start = 1'b1;
    repeat (3) @(posedge clk);
    #1 bp_start = 1'b0;
    repeat (6) @(negedge clk);
    chk("R11", "busy with lines disabled", busy, 0);

    // R11: enabled backplane pulses, start held 3 cycles, window of 25
    bp_en = 1'b1;
    push_run(1'b0, 25, 128);
    @(posedge clk); #1 bp_start = 1'b1;
    for (int i = 0; i < 25; i++) begin
      @(posedge clk); #1;
      if (i == 2) bp_start = 1'b0;
    end
    bp_stop = 1'b1;
    repeat (2) @(posedge clk);
    #1 bp_stop = 1'b0;
    wait_idle();
    flushed("R11");
    chk("R10", "evt_num0 after external run", evt_num0, 7);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule